// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDRAM device from power-on to a usable state and then paces its refresh. Coming out of reset it holds the command pins idle, with the clock enable high, for a pause of at least a configurable number of microseconds. The pause length in cycles is derived from a clock-frequency parameter. It then plays a fixed command sequence: one precharge of all banks, eight auto-refresh commands and one mode-register load. The mode register is loaded with burst length 1, sequential burst order and the configured CAS latency. Each command gap comes from the timing fields of the configuration word, given in clock cycles.

After the mode-register load, the block waits the mode-register delay plus three extra cycles and then raises `init_done`. That flag stays high until the next reset. From that point a reloading refresh timer raises a refresh request at every period. The request works as a valid/ready pair: `ref_req` is the valid side and `ref_ack` is the ready side. A request stays high, with back-pressure, until it is acknowledged. The timer keeps running while a request waits. A period that expires while a request is still pending merges into it and does not queue a second request.

The block also encodes the configured geometry into compact codes and reports the device size as a power of two in bytes. A refresh period of zero is rejected: the sequencer never leaves the pause, issues no command and raises `cfg_error`.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted and after its release, the pins idle as NOP with `sd_cke` high. The first command appears no earlier than P and no later than P+2 clock edges after reset release, where P = ceil(CLK_HZ·PAUSE_US/10^6).
- R2: The first command is a precharge-all, with `sd_addr[10]` = 1. The next command follows exactly max(t_rp, 2) cycles later.
- R3: Exactly eight auto-refresh commands follow the precharge-all. Consecutive auto-refreshes are spaced exactly max(t_rc, 2) cycles apart, and the spacing from the last auto-refresh to the mode load is the same.
- R4: The ninth command after the precharge-all is a single load-mode. On it, `sd_addr[2:0]` = 000 (burst length 1), `sd_addr[3]` = 0 (sequential), `sd_addr[6:4]` = CAS latency, all other address bits are 0 and `sd_ba` = 0.
- R5: `init_done` rises exactly t_mrd+3 cycles after the load-mode command. It stays high until reset, and no command is issued while it is high.
- R6: With `init_done` high, `ref_req` first rises exactly `cfg_ref_period` cycles after `init_done` rose. The timer then reloads, so expiries occur every `cfg_ref_period` cycles.
- R7: `ref_req` stays high until `ref_ack` is sampled high at a clock edge. It is low after that edge unless a new expiry falls on the same edge.
- R8: If `cfg_ref_period` is 0 when the pause ends, `cfg_error` goes high and stays high until reset, no command is issued and `init_done` stays low.
- R9: `col_code` = column bits − 8 (column bits 8..11), `row_code` = row bits − 11 (row bits 11..13) and `bank_code` = bank bits − 1 (bank bits 1..2). `mem_size_log2` = row+col+bank+2 for a 32-bit bus (`cfg_bus16`=0) or row+col+bank+1 for a 16-bit bus.
- R10: `sd_cs_n` is always low. The pin triple {ras_n,cas_n,we_n} encodes NOP = 111, precharge = 010, auto-refresh = 001 and load-mode = 000. Every cycle without a command is NOP, so at most one command is issued per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_col_bits | input | 4 | Column address bits (8..11) |
| cfg_row_bits | input | 5 | Row address bits (11..13) |
| cfg_bank_bits | input | 2 | Bank address bits (1..2) |
| cfg_bus16 | input | 1 | 1 = 16-bit data bus, 0 = 32-bit |
| cfg_cas_lat | input | 3 | CAS latency written to the mode register |
| cfg_t_rp | input | 4 | Precharge time, cycles |
| cfg_t_rc | input | 4 | Refresh cycle time, cycles |
| cfg_t_mrd | input | 4 | Mode-register delay, cycles |
| cfg_ref_period | input | 16 | Refresh period, cycles (0 illegal) |
| ref_ack | input | 1 | Refresh request accepted (ready) |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | 13 | Address bus |
| sd_ba | output | 2 | Bank address |
| init_done | output | 1 | Normal mode reached (sticky) |
| ref_req | output | 1 | Refresh request (valid), held until acknowledged |
| cfg_error | output | 1 | Zero refresh period detected |
| col_code | output | 2 | Encoded column width |
| row_code | output | 2 | Encoded row width |
| bank_code | output | 1 | Encoded bank width |
| mem_size_log2 | output | 6 | log2 of device size in bytes |

## Verification
The sequence is run with directed timing at both extremes: zero and one-cycle gaps that must be stretched to the two-cycle floor, and the maximum field values where the spacing equals the programmed time. These runs separate a correct gap count from one that is off by one or ignores the floor. Randomly drawn timings, CAS latencies and refresh periods then show that each spacing, the mode word and the refresh cadence follow their own field rather than a neighbour's. The refresh handshake is tried with a delayed acknowledge, which separates a held request from a one-cycle pulse. A zero refresh period is run on its own to show that the pause is never left. Random geometries with both bus widths exercise the size arithmetic.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;
  typedef enum logic [1:0] {
    CMD_NOP,
    CMD_PRE,
    CMD_REF,
    CMD_LMR
  } sdi_cmd_e;

  typedef enum logic [3:0] {
    ST_PAUSE,
    ST_PRE,
    ST_WAIT_RP,
    ST_REF,
    ST_WAIT_RC,
    ST_LMR,
    ST_WAIT_MRD,
    ST_NORMAL,
    ST_FAULT
  } sdi_state_e;

  // {ras_n, cas_n, we_n}
  localparam logic [2:0] PINS_NOP = 3'b111;
  localparam logic [2:0] PINS_PRE = 3'b010;
  localparam logic [2:0] PINS_REF = 3'b001;
  localparam logic [2:0] PINS_LMR = 3'b000;
endpackage

// File: rtl/sdi_geometry.sv
module sdi_geometry (
  input  logic [3:0] col_bits,
  input  logic [4:0] row_bits,
  input  logic [1:0] bank_bits,
  input  logic       bus16,
  output logic [1:0] col_code,
  output logic [1:0] row_code,
  output logic       bank_code,
  output logic [5:0] size_log2
);
  logic [3:0] col_m;
  logic [4:0] row_m;
  logic [1:0] bank_m;

  always_comb begin
    col_m     = col_bits - 4'd8;
    row_m     = row_bits - 5'd11;
    bank_m    = bank_bits - 2'd1;
    col_code  = col_m[1:0];
    row_code  = row_m[1:0];
    bank_code = bank_m[0];
    size_log2 = 6'(row_bits) + 6'(col_bits) + 6'(bank_bits) + (bus16 ? 6'd1 : 6'd2);
  end
endmodule

// File: rtl/sdi_refresh_timer.sv
module sdi_refresh_timer #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PER_W-1:0] period,
  input  logic             ack,
  output logic             req
);
  logic [PER_W-1:0] tcnt;
  logic             expire;

  assign expire = run && (tcnt <= PER_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt <= '0;
      req  <= 1'b0;
    end else begin
      if (!run || expire) tcnt <= period;
      else                tcnt <= tcnt - PER_W'(1);
      if (expire)   req <= 1'b1;
      else if (ack) req <= 1'b0;
    end
  end
endmodule

// File: rtl/sdi_cmd_drive.sv
module sdi_cmd_drive
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sdi_cmd_e          cmd,
  input  logic [2:0]        cas_lat,
  input  logic              normal,
  input  logic              fault,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic              done,
  output logic              err
);
  logic [2:0]        pins_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    pins_d = PINS_NOP;
    addr_d = '0;
    unique case (cmd)
      CMD_PRE: begin
        pins_d     = PINS_PRE;
        addr_d[10] = 1'b1;
      end
      CMD_REF: pins_d = PINS_REF;
      CMD_LMR: begin
        pins_d       = PINS_LMR;
        addr_d[6:4]  = cas_lat;
      end
      default: pins_d = PINS_NOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke                  <= 1'b1;
      cs_n                 <= 1'b0;
      {ras_n, cas_n, we_n} <= PINS_NOP;
      addr                 <= '0;
      ba                   <= '0;
      done                 <= 1'b0;
      err                  <= 1'b0;
    end else begin
      cke                  <= 1'b1;
      cs_n                 <= 1'b0;
      {ras_n, cas_n, we_n} <= pins_d;
      addr                 <= addr_d;
      ba                   <= '0;
      done                 <= normal;
      err                  <= fault;
    end
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_HZ   = 100_000_000,
  parameter int PAUSE_US = 200,
  parameter int ADDR_W   = 13,
  parameter int BA_W     = 2,
  parameter int TW       = 4,
  parameter int PER_W    = 16,
  parameter int NUM_REF  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        cfg_col_bits,
  input  logic [4:0]        cfg_row_bits,
  input  logic [1:0]        cfg_bank_bits,
  input  logic              cfg_bus16,
  input  logic [2:0]        cfg_cas_lat,
  input  logic [TW-1:0]     cfg_t_rp,
  input  logic [TW-1:0]     cfg_t_rc,
  input  logic [TW-1:0]     cfg_t_mrd,
  input  logic [PER_W-1:0]  cfg_ref_period,
  input  logic              ref_ack,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BA_W-1:0]   sd_ba,
  output logic              init_done,
  output logic              ref_req,
  output logic              cfg_error,
  output logic [1:0]        col_code,
  output logic [1:0]        row_code,
  output logic              bank_code,
  output logic [5:0]        mem_size_log2
);
  localparam int PAUSE_CYC = ((CLK_HZ / 1000) * PAUSE_US + 999) / 1000;
  localparam int PCW       = $clog2(PAUSE_CYC + 1);
  localparam int CNT_W     = (PCW > TW + 2) ? PCW : TW + 2;
  localparam int RCW       = $clog2(NUM_REF + 1);

  sdi_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [RCW-1:0]   nref;
  logic [CNT_W:0]   cnt_nxt;
  logic             pause_end;
  logic             rp_met, rc_met, mrd_met;
  sdi_cmd_e         cmd;

  assign cnt_nxt   = {1'b0, cnt} + (CNT_W+1)'(1);
  assign pause_end = {1'b0, cnt} >= (CNT_W+1)'(PAUSE_CYC - 1);
  assign rp_met    = cnt_nxt >= (CNT_W+1)'(cfg_t_rp);
  assign rc_met    = cnt_nxt >= (CNT_W+1)'(cfg_t_rc);
  assign mrd_met   = cnt_nxt >= ((CNT_W+1)'(cfg_t_mrd) + (CNT_W+1)'(3));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_PAUSE;
      cnt   <= '0;
      nref  <= '0;
    end else begin
      unique case (state)
        ST_PAUSE: begin
          if (pause_end) begin
            state <= (cfg_ref_period == '0) ? ST_FAULT : ST_PRE;
            cnt   <= '0;
          end else begin
            cnt <= cnt_nxt[CNT_W-1:0];
          end
        end
        ST_PRE: begin
          state <= ST_WAIT_RP;
          cnt   <= CNT_W'(1);
        end
        ST_WAIT_RP: begin
          if (rp_met) state <= ST_REF;
          else        cnt   <= cnt_nxt[CNT_W-1:0];
        end
        ST_REF: begin
          state <= ST_WAIT_RC;
          cnt   <= CNT_W'(1);
          nref  <= nref + RCW'(1);
        end
        ST_WAIT_RC: begin
          if (rc_met) state <= (nref == RCW'(NUM_REF)) ? ST_LMR : ST_REF;
          else        cnt   <= cnt_nxt[CNT_W-1:0];
        end
        ST_LMR: begin
          state <= ST_WAIT_MRD;
          cnt   <= CNT_W'(1);
        end
        ST_WAIT_MRD: begin
          if (mrd_met) state <= ST_NORMAL;
          else         cnt   <= cnt_nxt[CNT_W-1:0];
        end
        ST_NORMAL: state <= ST_NORMAL;
        default:   state <= ST_FAULT;
      endcase
    end
  end

  always_comb begin
    unique case (state)
      ST_PRE:  cmd = CMD_PRE;
      ST_REF:  cmd = CMD_REF;
      ST_LMR:  cmd = CMD_LMR;
      default: cmd = CMD_NOP;
    endcase
  end

  sdi_cmd_drive #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_drive (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd     (cmd),
    .cas_lat (cfg_cas_lat),
    .normal  (state == ST_NORMAL),
    .fault   (state == ST_FAULT),
    .cke     (sd_cke),
    .cs_n    (sd_cs_n),
    .ras_n   (sd_ras_n),
    .cas_n   (sd_cas_n),
    .we_n    (sd_we_n),
    .addr    (sd_addr),
    .ba      (sd_ba),
    .done    (init_done),
    .err     (cfg_error)
  );

  sdi_refresh_timer #(.PER_W(PER_W)) u_rtimer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (init_done),
    .period (cfg_ref_period),
    .ack    (ref_ack),
    .req    (ref_req)
  );

  sdi_geometry u_geom (
    .col_bits  (cfg_col_bits),
    .row_bits  (cfg_row_bits),
    .bank_bits (cfg_bank_bits),
    .bus16     (cfg_bus16),
    .col_code  (col_code),
    .row_code  (row_code),
    .bank_code (bank_code),
    .size_log2 (mem_size_log2)
  );
endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sd_cke,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [ADDR_W-1:0] sd_addr,
  input logic [BA_W-1:0]   sd_ba,
  input logic              init_done,
  input logic              ref_req,
  input logic              ref_ack,
  input logic              cfg_error,
  input logic [2:0]        cfg_cas_lat
);
  logic [2:0] trip;
  assign trip = {sd_ras_n, sd_cas_n, sd_we_n};

  p_cs_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sd_cs_n == 1'b0);

  p_legal_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trip == 3'b111 || trip == 3'b010 || trip == 3'b001 || trip == 3'b000);

  p_cke_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sd_cke);

  p_pre_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (trip == 3'b010) |-> sd_addr[10]);

  p_mode_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (trip == 3'b000) |-> (sd_addr[6:4] == cfg_cas_lat && sd_addr[3:0] == 4'd0 && sd_ba == '0));

  p_done_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  p_quiet_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> trip == 3'b111);

  p_req_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_ack) |=> ref_req);

  p_req_needs_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_req) |-> init_done);

  p_error_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |-> (trip == 3'b111 && !init_done));
endmodule

bind sdram_init_seq sdram_init_seq_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sd_cke      (sd_cke),
  .sd_cs_n     (sd_cs_n),
  .sd_ras_n    (sd_ras_n),
  .sd_cas_n    (sd_cas_n),
  .sd_we_n     (sd_we_n),
  .sd_addr     (sd_addr),
  .sd_ba       (sd_ba),
  .init_done   (init_done),
  .ref_req     (ref_req),
  .ref_ack     (ref_ack),
  .cfg_error   (cfg_error),
  .cfg_cas_lat (cfg_cas_lat)
);

// File: tb/sdram_init_seq_bench.sv
module sdram_init_seq_bench;
  localparam int CLK_HZ   = 1_000_000;
  localparam int PAUSE_US = 200;
  localparam int P        = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_col_bits = 4'd9;
  logic [4:0]  cfg_row_bits = 5'd12;
  logic [1:0]  cfg_bank_bits = 2'd2;
  logic        cfg_bus16 = 1'b0;
  logic [2:0]  cfg_cas_lat = 3'd2;
  logic [3:0]  cfg_t_rp = 4'd2;
  logic [3:0]  cfg_t_rc = 4'd6;
  logic [3:0]  cfg_t_mrd = 4'd2;
  logic [15:0] cfg_ref_period = 16'd20;
  logic        ref_ack = 1'b0;
  logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [12:0] sd_addr;
  logic [1:0]  sd_ba;
  logic        init_done, ref_req, cfg_error;
  logic [1:0]  col_code, row_code;
  logic        bank_code;
  logic [5:0]  mem_size_log2;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sdram_init_seq #(.CLK_HZ(CLK_HZ), .PAUSE_US(PAUSE_US)) u_sdram_init_seq (
    .clk(clk), .rst_n(rst_n),
    .cfg_col_bits(cfg_col_bits), .cfg_row_bits(cfg_row_bits),
    .cfg_bank_bits(cfg_bank_bits), .cfg_bus16(cfg_bus16),
    .cfg_cas_lat(cfg_cas_lat), .cfg_t_rp(cfg_t_rp), .cfg_t_rc(cfg_t_rc),
    .cfg_t_mrd(cfg_t_mrd), .cfg_ref_period(cfg_ref_period), .ref_ack(ref_ack),
    .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_ba(sd_ba),
    .init_done(init_done), .ref_req(ref_req), .cfg_error(cfg_error),
    .col_code(col_code), .row_code(row_code), .bank_code(bank_code),
    .mem_size_log2(mem_size_log2)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int gap_of(input int t);
    return (t < 2) ? 2 : t;
  endfunction

  function automatic int size_of(input int r, input int c, input int b, input bit b16);
    return r + c + b + (b16 ? 1 : 2);
  endfunction

  task automatic check_geom();
    #1;
    chk(col_code == 2'(cfg_col_bits - 8), "R9 col_code", col_code, cfg_col_bits - 8);
    chk(row_code == 2'(cfg_row_bits - 11), "R9 row_code", row_code, cfg_row_bits - 11);
    chk(bank_code == 1'(cfg_bank_bits - 1), "R9 bank_code", bank_code, cfg_bank_bits - 1);
    chk(int'(mem_size_log2) == size_of(cfg_row_bits, cfg_col_bits, cfg_bank_bits, cfg_bus16),
        "R9 mem_size_log2", mem_size_log2,
        size_of(cfg_row_bits, cfg_col_bits, cfg_bank_bits, cfg_bus16));
  endtask

  task automatic run_case(input int trp, input int trc, input int tmrd, input int cas, input int per);
    int ccyc[16];
    logic [2:0]  ccode[16];
    logic [12:0] caddr[16];
    logic [1:0]  cba[16];
    int ncmd = 0;
    int dcyc = -1;
    int n = 0;
    bit bad_pins = 0;
    bit reset_ok = 1;
    int r1;
    cfg_t_rp = 4'(trp); cfg_t_rc = 4'(trc); cfg_t_mrd = 4'(tmrd);
    cfg_cas_lat = 3'(cas); cfg_ref_period = 16'(per); ref_ack = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if ({sd_ras_n, sd_cas_n, sd_we_n} != 3'b111 || !sd_cke || init_done || ref_req) reset_ok = 0;
    end
    chk(reset_ok, "R1 reset idle", reset_ok, 1);
    rst_n = 1'b1;
    while (dcyc < 0 && n < P + 400) begin
      @(negedge clk); n++;
      if (sd_cs_n || !sd_cke) bad_pins = 1;
      if ({sd_ras_n, sd_cas_n, sd_we_n} != 3'b111) begin
        if (ncmd < 16) begin
          ccyc[ncmd] = n; ccode[ncmd] = {sd_ras_n, sd_cas_n, sd_we_n};
          caddr[ncmd] = sd_addr; cba[ncmd] = sd_ba;
        end
        ncmd++;
      end
      if (init_done) dcyc = n;
    end
    chk(ncmd == 10, "R3 command count", ncmd, 10);
    if (ncmd != 10 || dcyc < 0) return;
    chk(ccyc[0] >= P && ccyc[0] <= P + 2, "R1 pause length", ccyc[0], P);
    chk(ccode[0] == 3'b010 && caddr[0][10], "R2 precharge-all", {ccode[0], caddr[0]}, {3'b010, 13'h400});
    chk(ccyc[1] - ccyc[0] == gap_of(trp), "R2 t_rp gap", ccyc[1] - ccyc[0], gap_of(trp));
    for (int i = 1; i <= 8; i++) begin
      chk(ccode[i] == 3'b001, "R3 refresh code", ccode[i], 1);
      chk(ccyc[i + 1] - ccyc[i] == gap_of(trc), "R3 t_rc gap", ccyc[i + 1] - ccyc[i], gap_of(trc));
    end
    chk(ccode[9] == 3'b000, "R4 load-mode code", ccode[9], 0);
    chk(caddr[9] == 13'(cas << 4) && cba[9] == 2'd0, "R4 mode word", caddr[9], cas << 4);
    chk(dcyc - ccyc[9] == tmrd + 3, "R5 t_mrd margin", dcyc - ccyc[9], tmrd + 3);
    // refresh phase
    r1 = -1;
    while (r1 < 0 && n < dcyc + per + 10) begin
      if (ref_req) r1 = n;
      else begin @(negedge clk); n++; end
    end
    chk(r1 - dcyc == per, "R6 first request", r1 - dcyc, per);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); n++;
      chk(ref_req == 1'b1, "R7 held without ack", ref_req, 1);
    end
    ref_ack = 1'b1;
    @(negedge clk); n++;
    ref_ack = 1'b0;
    chk(ref_req == 1'b0, "R7 cleared by ack", ref_req, 0);
    while (!ref_req && n < r1 + per + 10) begin
      @(negedge clk); n++;
      if (!init_done || {sd_ras_n, sd_cas_n, sd_we_n} != 3'b111) bad_pins = 1;
    end
    chk(n - r1 == per, "R6 reload period", n - r1, per);
    chk(!bad_pins && init_done, "R10 R5 pins idle and done sticky", bad_pins, 0);
    ref_ack = 1'b1; @(negedge clk); ref_ack = 1'b0;
  endtask

  task automatic run_zero_period();
    bit quiet = 1;
    cfg_ref_period = 16'd0;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < P + 60; i++) begin
      @(negedge clk);
      if ({sd_ras_n, sd_cas_n, sd_we_n} != 3'b111 || init_done) quiet = 0;
    end
    chk(quiet, "R8 no command on zero period", quiet, 1);
    chk(cfg_error == 1'b1, "R8 error flag", cfg_error, 1);
    chk(init_done == 1'b0, "R8 init not done", init_done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    check_geom();
    // directed corners
    run_case(0, 1, 0, 2, 8);
    run_case(15, 15, 15, 3, 40);
    run_case(2, 2, 1, 7, 9);
    // random timings
    for (int k = 0; k < 6; k++) begin
      cfg_col_bits  = 4'(8 + $urandom_range(0, 3));
      cfg_row_bits  = 5'(11 + $urandom_range(0, 2));
      cfg_bank_bits = 2'(1 + $urandom_range(0, 1));
      cfg_bus16     = 1'($urandom_range(0, 1));
      check_geom();
      run_case($urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15),
               $urandom_range(0, 7), $urandom_range(8, 60));
    end
    run_zero_period();
    for (int k = 0; k < 8; k++) begin
      cfg_col_bits  = 4'(8 + $urandom_range(0, 3));
      cfg_row_bits  = 5'(11 + $urandom_range(0, 2));
      cfg_bank_bits = 2'(1 + $urandom_range(0, 1));
      cfg_bus16     = 1'(k[0]);
      check_geom();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule